// File: doc/BRIEF.md
# SPI Configuration Programming Sequencer

This block runs one complete programming session against the slave SPI configuration port of a target device. After a start pulse it sends a fixed series of command transfers. It checks the word the target returns after the enable step, switches the target into program mode, and streams the image as framed writes. It then closes the session with a disable command, a settling delay and a release command. Image bytes arrive on a valid/ready byte stream. The image length and a partial-reconfiguration request are sampled on the start pulse.

Before each transfer the sequencer asks an external status-poll unit whether the target is idle. Before the read-back transfer it also asks whether the target is ready. The poll unit answers with an acknowledge pulse and an error flag. The SPI side uses mode 0, sends MSB first, and runs a chip select that the sequencer controls. When a session ends it pulses done or holds an error code. A program-mode flag shows whether the target has been placed in program mode.

Top module: `spi_cfg_sequencer`

## Requirements
- R1: A full session sends these transfers in this order, each under its own chip-select assertion: 0x0B; then 0x01 followed by four read bytes (0x00 sent); then 0xAE 0x01; then the image frames; then 0x0C; then 0x23.
- R2: If any of the four read-back bytes is nonzero, the session stops after the read-back transfer with errCode=3, and no program-mode transfer is sent.
- R3: Each frame is one transfer of 17 bytes: 0xEE and then 16 image bytes in stream order. An image of N bytes produces N/16 frames.
- R4: A start with imageLen not a multiple of 16 ends at once with errCode=2. No poll request and no SPI transfer happen.
- R5: A start with partialReq=1 ends at once with errCode=1. No poll request and no SPI transfer happen.
- R6: Exactly one poll request precedes every transfer. pollNeedReady is 1 only for the poll before the read-back transfer. Chip select stays high while a poll is pending. A poll answered with pollErr=1 ends the session with errCode=4.
- R7: At least DELAY_US microseconds of clock cycles (CLK_HZ/1e6*DELAY_US) pass between the end of the 0x0C transfer and the start of the 0x23 transfer.
- R8: progMode rises on the edge that ends the 0xAE 0x01 transfer and falls on the edge that ends the 0x23 transfer. It is not changed at any other time.
- R9: Between separate transfers, chip select stays high for at least one SPI clock period (2*SCLK_HALF clock cycles).
- R10: After an error the block is idle with chip select high. errCode stays unchanged until the next start, which clears it. Error codes: 0 none, 1 partial, 2 length, 3 read-back, 4 poll.
- R11: SPI runs in mode 0, MSB first, and the clock is low whenever chip select is high. A successful session ends with a one-cycle done pulse.
- R12: inReady is high only during the payload byte slots of a frame. An image of length 0 is legal and runs the session with no frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted while idle |
| partialReq | input | 1 | Partial-reconfiguration request, sampled with start |
| imageLen | input | LEN_W | Image length in bytes, sampled with start |
| inData | input | 8 | Image byte |
| inValid | input | 1 | Image byte valid |
| inReady | output | 1 | Image byte accepted when high together with inValid |
| pollReq | output | 1 | Request to the status-poll unit |
| pollNeedReady | output | 1 | Poll must also see the ready state |
| pollAck | input | 1 | Poll finished, one cycle |
| pollErr | input | 1 | Poll failed, valid with pollAck |
| spiSclk | output | 1 | SPI clock |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data to target |
| spiMiso | input | 1 | SPI data from target |
| progMode | output | 1 | Target is in program mode |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished without error, one cycle |
| errCode | output | 3 | Error code of the last session |

## Verification
The control state machine decides the step and phase. A wrong value there shows up at once on the SPI pins. An extra, missing or reordered transfer is visible as soon as chip select rises, because each transfer's byte list is checked against the expected command sequence. A wrong program-mode state is caught in the same clock, since the flag is compared every cycle with a flag the bench derives from the transfers it has seen. A counter that is off by one shows up either as a short frame at the next chip-select rise, or as a gap or delay that is too short at the next chip-select fall.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int FRAME_BYTES = 16;
  localparam int FRAME_SHIFT = $clog2(FRAME_BYTES);
  localparam int IDX_W       = $clog2(FRAME_BYTES + 2);

  localparam logic [7:0] OP_ENABLE  = 8'h0B;
  localparam logic [7:0] OP_DISABLE = 8'h0C;
  localparam logic [7:0] OP_RDDATA  = 8'h01;
  localparam logic [7:0] OP_PROGSEL = 8'hAE;
  localparam logic [7:0] OP_PROGARG = 8'h01;
  localparam logic [7:0] OP_FRAME   = 8'hEE;
  localparam logic [7:0] OP_RELEASE = 8'h23;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_PARTIAL = 3'd1;
  localparam logic [2:0] ERR_LENGTH  = 3'd2;
  localparam logic [2:0] ERR_READBK  = 3'd3;
  localparam logic [2:0] ERR_POLL    = 3'd4;

  typedef enum logic [2:0] {
    ST_EN, ST_RD, ST_PROG, ST_FRAME, ST_DIS, ST_REL
  } step_e;

  typedef struct packed {
    logic       csLow;
    logic       csHigh;
    logic       sendByte;
    logic       useStream;
    logic [7:0] txByte;
    logic       loadLen;
    logic       decFrame;
    logic       startDelay;
  } ctrl_s;

  typedef struct packed {
    logic             engBusy;
    logic [IDX_W-1:0] byteIdx;
    logic             gapDone;
    logic             delayDone;
    logic             framesZero;
    logic             lenBad;
    logic             rxNonZero;
  } stat_s;

endpackage

// File: rtl/spi_byte_eng.sv
module spi_byte_eng #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] txByte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  localparam int DW = $clog2(SCLK_HALF) + 1;

  logic          active;
  logic          half;
  logic [2:0]    bitCnt;
  logic [DW-1:0] divCnt;
  logic [7:0]    shTx;
  logic [7:0]    shRx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      half     <= 1'b0;
      bitCnt   <= '0;
      divCnt   <= '0;
      shTx     <= '0;
      shRx     <= '0;
      sclk     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        half   <= 1'b0;
        bitCnt <= '0;
        divCnt <= '0;
        shTx   <= txByte;
        sclk   <= 1'b0;
      end else if (active) begin
        if (divCnt == DW'(SCLK_HALF - 1)) begin
          divCnt <= '0;
          if (!half) begin
            // rising edge: sample target data
            sclk <= 1'b1;
            half <= 1'b1;
            shRx <= {shRx[6:0], miso};
          end else begin
            // falling edge: present next bit
            sclk <= 1'b0;
            half <= 1'b0;
            shTx <= {shTx[6:0], 1'b0};
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end else begin
          divCnt <= divCnt + DW'(1);
        end
      end
    end
  end

  assign mosi   = shTx[7];
  assign rxByte = shRx;
  // busy covers the cycle in which the received byte is handed over
  assign busy   = active | byteDone;

endmodule

// File: rtl/spi_cfg_datapath.sv
module spi_cfg_datapath
  import spi_cfg_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int SCLK_HALF = 2,
  parameter int DLY_CYC   = 125000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_s            ctl,
  input  logic [LEN_W-1:0] imageLen,
  input  logic [7:0]       inData,
  input  logic             spiMiso,
  output stat_s            st,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi
);
  localparam int GAP_CYC = 2 * SCLK_HALF;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int DLY_W   = $clog2(DLY_CYC + 1);

  logic [IDX_W-1:0] byteIdx;
  logic [GAP_W-1:0] gapCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic [LEN_W-1:0] framesLeft;
  logic [31:0]      rxWord;
  logic [7:0]       txSel;
  logic [7:0]       rxByte;
  logic             engBusy;
  logic             byteDone;

  assign txSel = ctl.useStream ? inData : ctl.txByte;

  spi_byte_eng #(.SCLK_HALF(SCLK_HALF)) u_eng (
    .clk     (clk),
    .rstN    (rstN),
    .start   (ctl.sendByte),
    .txByte  (txSel),
    .miso    (spiMiso),
    .sclk    (spiSclk),
    .mosi    (spiMosi),
    .busy    (engBusy),
    .byteDone(byteDone),
    .rxByte  (rxByte)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiCsN     <= 1'b1;
      byteIdx    <= '0;
      gapCnt     <= '0;
      dlyCnt     <= '0;
      framesLeft <= '0;
      rxWord     <= '0;
    end else begin
      if (ctl.csLow) begin
        spiCsN  <= 1'b0;
        byteIdx <= '0;
      end else if (ctl.sendByte) begin
        byteIdx <= byteIdx + IDX_W'(1);
      end

      if (ctl.csHigh) begin
        spiCsN <= 1'b1;
        gapCnt <= GAP_W'(GAP_CYC);
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - GAP_W'(1);
      end

      if (ctl.startDelay) begin
        dlyCnt <= DLY_W'(DLY_CYC);
      end else if (dlyCnt != '0) begin
        dlyCnt <= dlyCnt - DLY_W'(1);
      end

      if (ctl.loadLen) begin
        framesLeft <= imageLen >> FRAME_SHIFT;
      end else if (ctl.decFrame && framesLeft != '0) begin
        framesLeft <= framesLeft - LEN_W'(1);
      end

      if (byteDone) begin
        rxWord <= {rxWord[23:0], rxByte};
      end
    end
  end

  always_comb begin
    st.engBusy    = engBusy;
    st.byteIdx    = byteIdx;
    st.gapDone    = (gapCnt == '0);
    st.delayDone  = (dlyCnt == '0);
    st.framesZero = (framesLeft == '0);
    st.lenBad     = ((imageLen & LEN_W'(FRAME_BYTES - 1)) != '0);
    st.rxNonZero  = (rxWord != '0);
  end

endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       partialReq,
  input  logic       inValid,
  input  logic       pollAck,
  input  logic       pollErr,
  input  stat_s      st,
  output ctrl_s      ctl,
  output logic       inReady,
  output logic       pollReq,
  output logic       pollNeedReady,
  output logic       progMode,
  output logic       busy,
  output logic       done,
  output logic [2:0] errCode
);
  typedef enum logic [2:0] {
    PH_IDLE, PH_POLL, PH_XFER, PH_GAP, PH_DELAY
  } phase_e;

  phase_e phase;
  step_e  step;

  function automatic logic [IDX_W-1:0] stepLen(step_e s);
    case (s)
      ST_RD:    return IDX_W'(5);
      ST_PROG:  return IDX_W'(2);
      ST_FRAME: return IDX_W'(FRAME_BYTES + 1);
      default:  return IDX_W'(1);
    endcase
  endfunction

  function automatic logic [7:0] stepByte(step_e s, logic [IDX_W-1:0] idx);
    case (s)
      ST_EN:    return OP_ENABLE;
      ST_RD:    return (idx == '0) ? OP_RDDATA : 8'h00;
      ST_PROG:  return (idx == '0) ? OP_PROGSEL : OP_PROGARG;
      ST_FRAME: return OP_FRAME;
      ST_DIS:   return OP_DISABLE;
      default:  return OP_RELEASE;
    endcase
  endfunction

  logic xferEnd;
  assign xferEnd = (phase == PH_XFER) && !st.engBusy && (st.byteIdx == stepLen(step));

  always_comb begin
    ctl     = '0;
    inReady = 1'b0;
    case (phase)
      PH_IDLE: ctl.loadLen = startReq && !partialReq && !st.lenBad;
      PH_POLL: ctl.csLow = pollAck && !pollErr;
      PH_XFER: begin
        if (xferEnd) begin
          ctl.csHigh   = 1'b1;
          ctl.decFrame = (step == ST_FRAME);
        end else if (!st.engBusy) begin
          if (step == ST_FRAME && st.byteIdx != '0) begin
            inReady       = 1'b1;
            ctl.useStream = 1'b1;
            ctl.sendByte  = inValid;
          end else begin
            ctl.sendByte = 1'b1;
            ctl.txByte   = stepByte(step, st.byteIdx);
          end
        end
      end
      PH_GAP:  ctl.startDelay = st.gapDone && (step == ST_DIS);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      step     <= ST_EN;
      progMode <= 1'b0;
      errCode  <= ERR_NONE;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (startReq) begin
          if (partialReq)    errCode <= ERR_PARTIAL;
          else if (st.lenBad) errCode <= ERR_LENGTH;
          else begin
            errCode <= ERR_NONE;
            step    <= ST_EN;
            phase   <= PH_POLL;
          end
        end
        PH_POLL: if (pollAck) begin
          if (pollErr) begin
            errCode <= ERR_POLL;
            phase   <= PH_IDLE;
          end else begin
            phase <= PH_XFER;
          end
        end
        PH_XFER: if (xferEnd) begin
          phase <= PH_GAP;
          case (step)
            ST_RD: if (st.rxNonZero) begin
              errCode <= ERR_READBK;
              phase   <= PH_IDLE;
            end
            ST_PROG: progMode <= 1'b1;
            ST_REL:  progMode <= 1'b0;
            default: ;
          endcase
        end
        PH_GAP: if (st.gapDone) begin
          case (step)
            ST_EN:   begin step <= ST_RD; phase <= PH_POLL; end
            ST_RD:   begin step <= ST_PROG; phase <= PH_POLL; end
            ST_PROG, ST_FRAME: begin
              step  <= st.framesZero ? ST_DIS : ST_FRAME;
              phase <= PH_POLL;
            end
            ST_DIS:  phase <= PH_DELAY;
            default: begin done <= 1'b1; phase <= PH_IDLE; end
          endcase
        end
        PH_DELAY: if (st.delayDone) begin
          step  <= ST_REL;
          phase <= PH_POLL;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign pollReq       = (phase == PH_POLL);
  assign pollNeedReady = (phase == PH_POLL) && (step == ST_RD);
  assign busy          = (phase != PH_IDLE);

endmodule

// File: rtl/spi_cfg_sequencer.sv
module spi_cfg_sequencer
  import spi_cfg_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int SCLK_HALF = 2,
  parameter int CLK_HZ    = 125000000,
  parameter int DELAY_US  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             partialReq,
  input  logic [LEN_W-1:0] imageLen,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             pollReq,
  output logic             pollNeedReady,
  input  logic             pollAck,
  input  logic             pollErr,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso,
  output logic             progMode,
  output logic             busy,
  output logic             done,
  output logic [2:0]       errCode
);
  localparam int DLY_CYC = (CLK_HZ / 1000000) * DELAY_US;

  ctrl_s ctl;
  stat_s st;

  spi_cfg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .partialReq   (partialReq),
    .inValid      (inValid),
    .pollAck      (pollAck),
    .pollErr      (pollErr),
    .st           (st),
    .ctl          (ctl),
    .inReady      (inReady),
    .pollReq      (pollReq),
    .pollNeedReady(pollNeedReady),
    .progMode     (progMode),
    .busy         (busy),
    .done         (done),
    .errCode      (errCode)
  );

  spi_cfg_datapath #(
    .LEN_W    (LEN_W),
    .SCLK_HALF(SCLK_HALF),
    .DLY_CYC  (DLY_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .imageLen(imageLen),
    .inData  (inData),
    .spiMiso (spiMiso),
    .st      (st),
    .spiSclk (spiSclk),
    .spiCsN  (spiCsN),
    .spiMosi (spiMosi)
  );

endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker #(
  parameter int SCLK_HALF = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       spiCsN,
  input logic       spiSclk,
  input logic       busy,
  input logic       done,
  input logic [2:0] errCode,
  input logic       inReady,
  input logic       pollReq,
  input logic       progMode
);
  logic [15:0] highRun;

  always_ff @(posedge clk) begin
    if (!rstN)                 highRun <= 16'hFFFF;
    else if (!spiCsN)          highRun <= '0;
    else if (highRun != 16'hFFFF) highRun <= highRun + 16'd1;
  end

  a_r11_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  a_r10_error_is_idle: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 3'd0) |-> (!busy && spiCsN));

  a_r12_ready_inside_xfer: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !spiCsN);

  a_r6_poll_with_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    pollReq |-> spiCsN);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_prog_set_at_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> $rose(spiCsN));

  a_r8_prog_clear_at_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progMode) |-> $rose(spiCsN));

  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> ($past(highRun) >= 16'(2 * SCLK_HALF)));

endmodule

bind spi_cfg_sequencer spi_cfg_checker #(.SCLK_HALF(SCLK_HALF)) u_chk (.*);

// File: tb/test_spi_cfg_sequencer.sv
module test_spi_cfg_sequencer;
  localparam int LEN_W   = 24;
  localparam int HALF    = 2;
  localparam int DLY_US  = 20;
  localparam int DLY_CYC = 125 * DLY_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, partialReq = 1'b0;
  logic [LEN_W-1:0] imageLen = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inReady;
  logic pollReq, pollNeedReady, pollAck = 1'b0, pollErr = 1'b0;
  logic spiSclk, spiCsN, spiMosi, spiMiso = 1'b0;
  logic progMode, busy, done;
  logic [2:0] errCode;

  always #4 clk = ~clk;

  spi_cfg_sequencer #(.LEN_W(LEN_W), .SCLK_HALF(HALF), .CLK_HZ(125000000),
                      .DELAY_US(DLY_US)) i_spi_cfg_sequencer (.*);

  int total = 0, bad = 0, cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---- behavioural target model ----
  logic [31:0] rdResult = '0;
  int   bits = 0;
  logic [7:0] curByte;
  byte  unsigned cur[$];
  byte  unsigned logB[$];
  int   logL[$];
  int   fallCyc = 0, riseCyc = -1000, disRise = 0;
  bit   expProg = 1'b0;

  function automatic logic respBit(int n);
    if (n < 8 || n >= 40) return 1'b0;
    return rdResult[31 - (n - 8)];
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge spiCsN) begin
    if (rstN) begin
      check(cyc - riseCyc >= 2 * HALF, "R9", "cs high gap", cyc - riseCyc, 2 * HALF);
      fallCyc = cyc;
    end
    bits = 0;
    cur.delete();
    spiMiso = respBit(0);
  end

  always @(posedge spiSclk) if (!spiCsN) begin
    curByte = {curByte[6:0], spiMosi};
    bits++;
    if (bits % 8 == 0) cur.push_back(curByte);
  end

  always @(negedge spiSclk) spiMiso = respBit(bits);

  always @(posedge spiCsN) if (rstN) begin
    riseCyc = cyc;
    logL.push_back(cur.size());
    foreach (cur[i]) logB.push_back(cur[i]);
    if (cur.size() == 2 && cur[0] == 8'hAE && cur[1] == 8'h01) expProg = 1'b1;
    if (cur.size() == 1 && cur[0] == 8'h0C) disRise = cyc;
    if (cur.size() == 1 && cur[0] == 8'h23) begin
      expProg = 1'b0;
      check(fallCyc - disRise >= DLY_CYC, "R7", "post-disable delay", fallCyc - disRise, DLY_CYC);
    end
  end

  // ---- status-poll unit model ----
  int pollCnt = 0, readyPolls = 0, failAt = -1, pollWait = 0;
  always @(negedge clk) begin
    if (pollAck) begin
      pollAck = 1'b0; pollErr = 1'b0; pollWait = 0;
    end else if (pollReq) begin
      pollWait++;
      if (pollWait == 3) begin
        check(spiCsN == 1'b1, "R6", "cs during poll", spiCsN, 1);
        if (pollNeedReady) readyPolls++;
        pollErr = (pollCnt == failAt);
        pollAck = 1'b1;
        pollCnt++;
      end
    end
  end

  // ---- image stream ----
  int imgIdx = 0;
  function automatic byte unsigned imgByte(int i);
    return byte'((i * 7 + 3) & 255);
  endfunction
  always @(posedge clk) if (inValid && inReady) imgIdx++;
  always @(negedge clk) begin
    inData  = imgByte(imgIdx);
    inValid = (cyc % 5) != 0;
  end

  // ---- per-clock comparison ----
  always @(negedge clk) if (rstN) begin
    check(progMode == expProg, "R8", "progMode vs model", progMode, expProg);
    if (!busy) check(spiCsN == 1'b1, "R10", "cs while idle", spiCsN, 1);
    if (!spiCsN) check(inReady == 1'b0 || busy, "R12", "ready while busy", inReady, 0);
  end

  int doneCnt = 0;
  always @(negedge clk) if (done) doneCnt++;

  // ---- expectation building ----
  byte unsigned expB[$];
  int expL[$];
  task automatic ex1(byte unsigned b);
    expB.push_back(b); expL.push_back(1);
  endtask
  task automatic expPrefix();
    ex1(8'h0B);
    expB.push_back(8'h01); repeat (4) expB.push_back(8'h00); expL.push_back(5);
  endtask
  task automatic expProgAndFrames(int len);
    expB.push_back(8'hAE); expB.push_back(8'h01); expL.push_back(2);
    for (int f = 0; f < len / 16; f++) begin
      expB.push_back(8'hEE);
      for (int k = 0; k < 16; k++) expB.push_back(imgByte(f * 16 + k));
      expL.push_back(17);
    end
    ex1(8'h0C); ex1(8'h23);
  endtask

  task automatic compareLog(string req);
    bit ok = (logL.size() == expL.size()) && (logB.size() == expB.size());
    check(logL.size() == expL.size(), req, "transfer count", logL.size(), expL.size());
    if (ok) begin
      foreach (expL[i]) check(logL[i] == expL[i], req, "transfer length", logL[i], expL[i]);
      foreach (expB[i]) check(logB[i] == expB[i], req, "transfer byte", logB[i], expB[i]);
    end
  endtask

  task automatic runSession(int len, bit part, logic [31:0] rd, int failPoll);
    logB.delete(); logL.delete(); expB.delete(); expL.delete();
    imgIdx = 0; pollCnt = 0; readyPolls = 0; doneCnt = 0;
    failAt = failPoll; rdResult = rd;
    @(negedge clk);
    imageLen = LEN_W'(len); partialReq = part; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; partialReq = 1'b0;
    for (int n = 0; n < 60000 && busy; n++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(spiCsN == 1 && spiSclk == 0, "R11", "reset bus idle", {spiCsN, spiSclk}, 2);
    check(busy == 0 && progMode == 0 && errCode == 0, "R10", "reset status",
          {busy, progMode, errCode}, 0);
    check(inReady == 0 && pollReq == 0, "R12", "reset handshakes", {inReady, pollReq}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // full session, three frames
    runSession(48, 0, 32'h0, -1);
    expPrefix(); expProgAndFrames(48);
    compareLog("R1");
    check(imgIdx == 48, "R3", "payload bytes consumed", imgIdx, 48);
    check(pollCnt == 8, "R6", "poll count", pollCnt, 8);
    check(readyPolls == 1, "R6", "ready polls", readyPolls, 1);
    check(doneCnt == 1, "R11", "done pulses", doneCnt, 1);
    check(errCode == 0 && progMode == 0, "R8", "end state", {errCode, progMode}, 0);

    // bad length
    runSession(40, 0, 32'h0, -1);
    check(errCode == 2, "R4", "length error code", errCode, 2);
    check(logL.size() == 0 && pollCnt == 0, "R4", "no activity", logL.size() + pollCnt, 0);

    // partial request
    runSession(32, 1, 32'h0, -1);
    check(errCode == 1, "R5", "partial error code", errCode, 1);
    check(logL.size() == 0 && pollCnt == 0, "R5", "no activity", logL.size() + pollCnt, 0);

    // nonzero read-back
    runSession(32, 0, 32'h0000_0100, -1);
    expPrefix();
    compareLog("R2");
    check(errCode == 3, "R2", "readback error code", errCode, 3);
    check(progMode == 0 && doneCnt == 0, "R10", "no program mode or done", {progMode, doneCnt}, 0);

    // zero length image: error code cleared by new start
    runSession(0, 0, 32'h0, -1);
    expPrefix(); expProgAndFrames(0);
    compareLog("R12");
    check(errCode == 0, "R10", "error cleared on start", errCode, 0);
    check(imgIdx == 0, "R12", "no payload taken", imgIdx, 0);

    // poll failure on the ready poll
    runSession(16, 0, 32'h0, 1);
    check(errCode == 4, "R6", "poll error code", errCode, 4);
    check(logL.size() == 1, "R6", "stopped after enable", logL.size(), 1);
    repeat (20) @(negedge clk);
    check(errCode == 4 && spiCsN == 1, "R10", "error held", errCode, 4);

    // one frame with read-back in upper byte zero, different data
    runSession(16, 0, 32'h0, -1);
    expPrefix(); expProgAndFrames(16);
    compareLog("R3");
    check(doneCnt == 1, "R11", "done after single frame", doneCnt, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule